// File: doc/BRIEF.md
# Camera Input Sync Conditioner

This block sits between the parallel pins of an external image sensor and the capture logic. It takes an 8-bit pixel bus, a pixel clock and the two line/frame timing strobes, and it runs entirely in the fast system clock domain. The pixel clock is oversampled as a data signal rather than used as a clock. Each of the three timing inputs can be inverted on its own, so that downstream logic always sees a rising pixel-clock edge and active-high frame and line strobes. The line strobe can also be suppressed for as long as the frame strobe is active.

For bring-up without a sensor, an internal generator can replace the incoming pixel bytes with one of three patterns: eight vertical colour bars, a ramp that follows the column, or a ramp that follows the line. The generator is honoured only when the input format field selects 8-bit ITU-601 capture. In every other format the incoming bytes pass through unchanged. A single write-only control word holds the inversion bits, the mask, the pattern select, the input format and the level of the sensor reset/power-down pin.

Every conditioned pixel-clock rising edge produces a one-cycle `out_valid` pulse. Together with that pulse, the strobe outputs and `out_data` are updated. They then hold their values until the next edge.

Top module: `cam_sync_front`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `out_valid`, `out_vsync`, `out_href`, `out_data` and `cam_rst_o` are all 0, and every control field is 0.
- R2: A write (`cfg_we` high) loads the control word on that edge. Bit 0 inverts the pixel clock, bit 1 inverts the frame strobe, bit 2 inverts the line strobe, bit 3 enables line masking, bits 5:4 select the pattern, bits 7:6 select the input format and bit 8 is the sensor reset level.
- R3: `out_vsync` equals the raw frame strobe XOR bit 1, and `out_href` (unmasked) equals the raw line strobe XOR bit 2, both as sampled at the pixel-clock edge.
- R4: Each rising edge of (raw pixel clock XOR bit 0) gives exactly one single-cycle `out_valid` pulse. The data captured is the data present at that conditioned edge. `out_data` changes only in a cycle where `out_valid` is high.
- R5: When bit 3 is 1 and the conditioned frame strobe is high, `out_href` is 0. When bit 3 is 0, the line strobe is not affected by the frame strobe.
- R6: With pattern select 00, `out_data` equals the captured input byte.
- R7: Pattern 10 (horizontal ramp) outputs the column index modulo 256, counting from 0 at the first active pixel of each line.
- R8: Pattern 11 (vertical ramp) outputs the line index modulo 256, counting from 0 at the first line after the frame strobe rises.
- R9: Pattern 01 splits `LINE_W` pixels into eight bars of `LINE_W/8` pixels each. Bars 0 to 7 carry 0xEB, 0xD2, 0xAA, 0x91, 0x6A, 0x51, 0x29 and 0x10. Pixels beyond the last bar keep bar 7.
- R10: The column and line counters return to 0 at the rising edge of the conditioned frame strobe. The line counter advances, and the column counter returns to 0, when the conditioned line strobe falls.
- R11: Patterns are used only when the input format field (bits 7:6) is 00 (8-bit ITU-601). For 01 (16-bit) and 1x (ITU-656), the input byte passes through whatever the pattern select holds.
- R12: The column counter stops at `MAX_W-1` and the line counter stops at `MAX_H-1`.
- R13: `cam_rst_o` equals control bit 8 from the edge of the write onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than twice the pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 9 | Control word value |
| cam_pclk_i | input | 1 | Raw sensor pixel clock |
| cam_vsync_i | input | 1 | Raw sensor frame strobe |
| cam_href_i | input | 1 | Raw sensor line strobe |
| cam_data_i | input | PIX_W | Raw sensor pixel byte |
| out_valid | output | 1 | One-cycle pulse per conditioned pixel-clock edge |
| out_vsync | output | 1 | Conditioned active-high frame strobe |
| out_href | output | 1 | Conditioned, optionally masked, active-high line strobe |
| out_data | output | PIX_W | Selected pixel byte |
| cam_rst_o | output | 1 | Sensor reset/power-down level |

## Verification
The capture path is driven with pixel bytes whose complement sits on the bus during the opposite pixel-clock phase. A pixel-clock inversion that is ignored therefore shows up as a wrong byte, not just as a shifted pulse. Each ramp is run over lines that are longer than the column limit and over more lines than the row limit, so that wrap, restart on the frame strobe and saturation are told apart. The colour bar line uses a narrow bench bar width, so that every bar boundary is crossed. The same pattern selects are repeated under the non-601 formats, to show that the incoming bytes win there. The mask is tried both with the frame strobe high and with it low.

// File: rtl/cam_fe_pkg.sv
// Shared types for the camera sync conditioner.
// Assumes: one control word, packed with the pixel-clock invert bit in bit 0.
package cam_fe_pkg;

    typedef enum logic [1:0] {
        PAT_EXT   = 2'b00,
        PAT_BARS  = 2'b01,
        PAT_HRAMP = 2'b10,
        PAT_VRAMP = 2'b11
    } pat_sel_e;

    typedef enum logic [1:0] {
        FMT_601_8  = 2'b00,
        FMT_601_16 = 2'b01,
        FMT_656    = 2'b10,
        FMT_656_B  = 2'b11
    } in_fmt_e;

    typedef struct packed {
        logic     cam_rst;    // bit 8
        in_fmt_e  fmt;        // bits 7:6
        pat_sel_e pat;        // bits 5:4
        logic     href_mask;  // bit 3
        logic     inv_href;   // bit 2
        logic     inv_vsync;  // bit 1
        logic     inv_pclk;   // bit 0
    } fe_cfg_t;

    localparam int CFG_W = $bits(fe_cfg_t);

    // Fixed byte for each of the eight colour bars.
    function automatic logic [7:0] bar_level(input logic [2:0] idx);
        logic [7:0] lvl;
        case (idx)
            3'd0:    lvl = 8'hEB;
            3'd1:    lvl = 8'hD2;
            3'd2:    lvl = 8'hAA;
            3'd3:    lvl = 8'h91;
            3'd4:    lvl = 8'h6A;
            3'd5:    lvl = 8'h51;
            3'd6:    lvl = 8'h29;
            default: lvl = 8'h10;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/cam_fe_ctrl.sv
// Control word holder for the camera sync conditioner.
// What it does: latches the full control word on a write strobe.
// Assumes: there is no readback, and reset clears every field.
module cam_fe_ctrl
    import cam_fe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output fe_cfg_t          cfg
);

    // Load the control word on a write; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (we) begin
            cfg <= fe_cfg_t'(wdata);
        end
    end

endmodule

// File: rtl/cam_fe_cond.sv
// Input conditioner.
// What it does: registers the raw sensor pins once, applies the per-signal
// polarity inversion and the line mask, and detects rising edges of the
// conditioned pixel clock.
// Assumes: the system clock is more than twice the pixel clock, and the pins
// are already synchronous or slow enough for a single register stage.
module cam_fe_cond #(
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pclk_i,
    input  logic             vsync_i,
    input  logic             href_i,
    input  logic [PIX_W-1:0] data_i,
    input  logic             inv_pclk,
    input  logic             inv_vsync,
    input  logic             inv_href,
    input  logic             href_mask,
    output logic             tick,
    output logic             vsync_c,
    output logic             href_c,
    output logic [PIX_W-1:0] data_q
);

    logic pclk_q, vsync_q, href_q, pclk_prev;
    logic pclk_c;

    // Sample all raw pins together so that they stay aligned.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pclk_q  <= 1'b0;
            vsync_q <= 1'b0;
            href_q  <= 1'b0;
            data_q  <= '0;
        end else begin
            pclk_q  <= pclk_i;
            vsync_q <= vsync_i;
            href_q  <= href_i;
            data_q  <= data_i;
        end
    end

    // Polarity is fixed before the edge detection.
    assign pclk_c  = pclk_q ^ inv_pclk;
    assign vsync_c = vsync_q ^ inv_vsync;
    assign href_c  = (href_q ^ inv_href) & ~(href_mask & vsync_c);

    // Keep the previous conditioned pixel-clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pclk_prev <= 1'b0;
        else        pclk_prev <= pclk_c;
    end

    assign tick = pclk_c & ~pclk_prev;

endmodule

// File: rtl/cam_fe_patgen.sv
// Test pattern generator.
// What it does: tracks the column and line position from the conditioned
// strobes and forms the colour bar, horizontal ramp or vertical ramp byte.
// Assumes: `tick` marks one pixel, and the strobes are active high.
// Bar width is LINE_W/8, counted without a divider.
module cam_fe_patgen
    import cam_fe_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int MAX_W  = 1280,
    parameter int MAX_H  = 1024,
    parameter int LINE_W = 1280,
    localparam int COL_W = $clog2(MAX_W),
    localparam int ROW_W = $clog2(MAX_H)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             vsync_c,
    input  logic             href_c,
    input  pat_sel_e         pat,
    output logic [PIX_W-1:0] pat_px,
    output logic [COL_W-1:0] col_q,
    output logic [ROW_W-1:0] row_q
);

    localparam int BAR_W = (LINE_W / 8 > 0) ? LINE_W / 8 : 1;
    localparam int BP_W  = (BAR_W > 1) ? $clog2(BAR_W) : 1;
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(MAX_W - 1);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(MAX_H - 1);
    localparam logic [BP_W-1:0]  BP_LAST  = BP_W'(BAR_W - 1);

    logic            vs_prev, hr_prev;
    logic [BP_W-1:0] bar_pos;
    logic [2:0]      bar_idx;
    logic            frame_start;

    assign frame_start = vsync_c & ~vs_prev;

    // Position counters: restart on frame start, step per active pixel,
    // advance the line at the end of the line strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vs_prev <= 1'b0;
            hr_prev <= 1'b0;
            col_q   <= '0;
            row_q   <= '0;
            bar_pos <= '0;
            bar_idx <= '0;
        end else if (tick) begin
            vs_prev <= vsync_c;
            hr_prev <= href_c;
            if (frame_start) begin
                col_q   <= '0;
                row_q   <= '0;
                bar_pos <= '0;
                bar_idx <= '0;
            end else if (href_c) begin
                if (col_q != COL_LAST) col_q <= col_q + 1'b1;
                if (bar_pos == BP_LAST) begin
                    bar_pos <= '0;
                    if (bar_idx != 3'd7) bar_idx <= bar_idx + 3'd1;
                end else begin
                    bar_pos <= bar_pos + 1'b1;
                end
            end else if (hr_prev) begin
                col_q   <= '0;
                bar_pos <= '0;
                bar_idx <= '0;
                if (row_q != ROW_LAST) row_q <= row_q + 1'b1;
            end
        end
    end

    // Form the pattern byte for the current position.
    always_comb begin
        unique case (pat)
            PAT_BARS:  pat_px = PIX_W'(bar_level(bar_idx));
            PAT_HRAMP: pat_px = PIX_W'(8'(col_q));
            PAT_VRAMP: pat_px = PIX_W'(8'(row_q));
            default:   pat_px = '0;
        endcase
    end

endmodule

// File: rtl/cam_sync_front.sv
// Top of the camera sync conditioner.
// What it does: holds the control word, conditions the sensor pins, picks
// the sensor byte or the pattern byte, and registers all outputs on each
// conditioned pixel-clock edge.
// Assumes: patterns are honoured in 8-bit 601 format only.
module cam_sync_front
    import cam_fe_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int MAX_W  = 1280,
    parameter int MAX_H  = 1024,
    parameter int LINE_W = 1280
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             cam_pclk_i,
    input  logic             cam_vsync_i,
    input  logic             cam_href_i,
    input  logic [PIX_W-1:0] cam_data_i,
    output logic             out_valid,
    output logic             out_vsync,
    output logic             out_href,
    output logic [PIX_W-1:0] out_data,
    output logic             cam_rst_o
);

    localparam int COL_W = $clog2(MAX_W);
    localparam int ROW_W = $clog2(MAX_H);

    fe_cfg_t          cfg;
    logic             tick, vsync_c, href_c;
    logic [PIX_W-1:0] data_q, pat_px, src_px;
    logic [COL_W-1:0] pat_col;
    logic [ROW_W-1:0] pat_row;
    logic             use_pat;

    cam_fe_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    cam_fe_cond #(.PIX_W(PIX_W)) u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .pclk_i    (cam_pclk_i),
        .vsync_i   (cam_vsync_i),
        .href_i    (cam_href_i),
        .data_i    (cam_data_i),
        .inv_pclk  (cfg.inv_pclk),
        .inv_vsync (cfg.inv_vsync),
        .inv_href  (cfg.inv_href),
        .href_mask (cfg.href_mask),
        .tick      (tick),
        .vsync_c   (vsync_c),
        .href_c    (href_c),
        .data_q    (data_q)
    );

    cam_fe_patgen #(
        .PIX_W  (PIX_W),
        .MAX_W  (MAX_W),
        .MAX_H  (MAX_H),
        .LINE_W (LINE_W)
    ) u_pat (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .vsync_c (vsync_c),
        .href_c  (href_c),
        .pat     (cfg.pat),
        .pat_px  (pat_px),
        .col_q   (pat_col),
        .row_q   (pat_row)
    );

    // A pattern replaces the sensor byte only in 8-bit 601 format.
    assign use_pat = (cfg.fmt == FMT_601_8) && (cfg.pat != PAT_EXT);
    assign src_px  = use_pat ? pat_px : data_q;

    // Output stage: pulse per edge; the other outputs update only on that edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_vsync <= 1'b0;
            out_href  <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= tick;
            if (tick) begin
                out_vsync <= vsync_c;
                out_href  <= href_c;
                out_data  <= src_px;
            end
        end
    end

    assign cam_rst_o = cfg.cam_rst;

endmodule

// File: rtl/cam_sync_front_chk.sv
// Property checker for cam_sync_front, attached to it by bind.
module cam_sync_front_chk
    import cam_fe_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int MAX_W = 1280,
    parameter int MAX_H = 1024,
    localparam int COL_W = $clog2(MAX_W),
    localparam int ROW_W = $clog2(MAX_H)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [CFG_W-1:0] cfg_wdata,
    input logic             out_valid,
    input logic             out_vsync,
    input logic             out_href,
    input logic [PIX_W-1:0] out_data,
    input logic             cam_rst_o,
    input logic             mask_q,
    input logic [COL_W-1:0] col,
    input logic [ROW_W-1:0] row
);

    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R4

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_data) |-> out_valid); // R4

    AST_HREF_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(mask_q) && out_vsync) |-> !out_href); // R5

    AST_CAM_RST_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cam_rst_o == $past(cfg_wdata[CFG_W-1]))); // R13

    AST_POS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (col <= COL_W'(MAX_W - 1)) && (row <= ROW_W'(MAX_H - 1))); // R12

endmodule

bind cam_sync_front cam_sync_front_chk #(
    .PIX_W (PIX_W),
    .MAX_W (MAX_W),
    .MAX_H (MAX_H)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .out_valid (out_valid),
    .out_vsync (out_vsync),
    .out_href  (out_href),
    .out_data  (out_data),
    .cam_rst_o (cam_rst_o),
    .mask_q    (cfg.href_mask),
    .col       (pat_col),
    .row       (pat_row)
);

// File: tb/cam_sync_front_test.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module cam_sync_front_test;

    localparam int MAXW  = 20;
    localparam int MAXH  = 6;
    localparam int LINEW = 16;
    localparam int BARW  = LINEW / 8;
    localparam logic [7:0] BAR_V [8] = '{8'hEB, 8'hD2, 8'hAA, 8'h91,
                                          8'h6A, 8'h51, 8'h29, 8'h10};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [8:0] cfg_wdata = '0;
    logic       cam_pclk_i = 1'b0, cam_vsync_i = 1'b0, cam_href_i = 1'b0;
    logic [7:0] cam_data_i = '0;
    logic       out_valid, out_vsync, out_href, cam_rst_o;
    logic [7:0] out_data;

    int n_chk = 0;
    int n_bad = 0;
    logic pinv = 0, vinv = 0, hinv = 0;
    int   cap_n;
    logic [7:0] cap_d;
    logic cap_v, cap_h;

    always #2.5 clk = ~clk;

    cam_sync_front #(.PIX_W(8), .MAX_W(MAXW), .MAX_H(MAXH), .LINE_W(LINEW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cam_pclk_i(cam_pclk_i), .cam_vsync_i(cam_vsync_i), .cam_href_i(cam_href_i),
        .cam_data_i(cam_data_i), .out_valid(out_valid), .out_vsync(out_vsync),
        .out_href(out_href), .out_data(out_data), .cam_rst_o(cam_rst_o)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Write the control word; park the pins at their idle (inactive) levels.
    task automatic wr_cfg(input logic ip, input logic iv, input logic ih, input logic msk,
                          input logic [1:0] pat, input logic [1:0] fmt, input logic cr);
        cfg_wdata = {cr, fmt, pat, msk, ih, iv, ip};
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        pinv = ip; vinv = iv; hinv = ih;
        cam_pclk_i = pinv; cam_vsync_i = vinv; cam_href_i = hinv;
        repeat (4) @(negedge clk);
    endtask

    // One pixel period: the complement byte in the first phase, the real byte after the edge.
    task automatic pix(input logic v, input logic h, input logic [7:0] d);
        cap_n = 0;
        cam_vsync_i = v ^ vinv;
        cam_href_i  = h ^ hinv;
        cam_pclk_i  = pinv;
        cam_data_i  = ~d;
        for (int ph = 0; ph < 2; ph++) begin
            if (ph == 1) begin
                cam_pclk_i = ~pinv;
                cam_data_i = d;
            end
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                if (out_valid) begin
                    cap_n++;
                    cap_d = out_data; cap_v = out_vsync; cap_h = out_href;
                end
            end
        end
        chk(cap_n == 1, "R4 pulse count", cap_n, 1);
    endtask

    function automatic logic [7:0] ext_px(input int c, input int l);
        return 8'(c * 7 + l * 13 + 5);
    endfunction

    function automatic logic [7:0] exp_px(input int pat, input int fmt, input int c, input int l);
        int cs = (c > MAXW - 1) ? MAXW - 1 : c;
        int ls = (l > MAXH - 1) ? MAXH - 1 : l;
        int b  = (c / BARW > 7) ? 7 : c / BARW;
        if (fmt != 0 || pat == 0) return ext_px(c, l);
        case (pat)
            1:       return BAR_V[b];
            2:       return 8'(cs);
            default: return 8'(ls);
        endcase
    endfunction

    // A frame strobe, one blank, then lines of active pixels with blanking between them.
    task automatic frame(input int pat, input int fmt, input int nl, input int np, input string req);
        pix(1, 0, 8'h00); pix(1, 0, 8'h00); pix(0, 0, 8'h00);
        for (int l = 0; l < nl; l++) begin
            for (int c = 0; c < np; c++) begin
                pix(0, 1, ext_px(c, l));
                chk(cap_d == exp_px(pat, fmt, c, l), req, cap_d, exp_px(pat, fmt, c, l));
            end
            pix(0, 0, 8'h00); pix(0, 0, 8'h00);
        end
    endtask

    task automatic t_reset;
        chk(out_valid == 0 && out_vsync == 0 && out_href == 0, "R1 strobes", {out_valid, out_vsync, out_href}, 0);
        chk(out_data == 0, "R1 data", out_data, 0);
        chk(cam_rst_o == 0, "R1 cam_rst", cam_rst_o, 0);
    endtask

    task automatic t_camrst;
        wr_cfg(0, 0, 0, 0, 2'b00, 2'b00, 1);
        chk(cam_rst_o == 1, "R13 R2 set", cam_rst_o, 1);
        wr_cfg(0, 0, 0, 0, 2'b00, 2'b00, 0);
        chk(cam_rst_o == 0, "R13 clear", cam_rst_o, 0);
    endtask

    task automatic t_passthru;
        wr_cfg(0, 0, 0, 0, 2'b00, 2'b00, 0);
        pix(0, 1, 8'h5A);
        chk(cap_d == 8'h5A, "R6 data", cap_d, 8'h5A);
        chk(cap_h == 1 && cap_v == 0, "R6 strobes", {cap_v, cap_h}, 1);
        pix(1, 0, 8'hC3);
        chk(cap_d == 8'hC3 && cap_v == 1 && cap_h == 0, "R6 second", {cap_v, cap_h, cap_d}, {1'b1, 1'b0, 8'hC3});
    endtask

    task automatic t_polarity;
        wr_cfg(0, 1, 1, 0, 2'b00, 2'b00, 0);
        pix(0, 1, 8'h11);
        chk(cap_v == 0 && cap_h == 1, "R3 inverted low vs", {cap_v, cap_h}, 1);
        pix(1, 0, 8'h22);
        chk(cap_v == 1 && cap_h == 0, "R3 inverted high vs", {cap_v, cap_h}, 2);
    endtask

    task automatic t_pclk_inv;
        wr_cfg(1, 0, 0, 0, 2'b00, 2'b00, 0);
        pix(0, 1, 8'h3C);
        chk(cap_d == 8'h3C, "R4 inverted pclk data", cap_d, 8'h3C);
        pix(0, 1, 8'h96);
        chk(cap_d == 8'h96, "R4 inverted pclk data 2", cap_d, 8'h96);
    endtask

    task automatic t_mask;
        wr_cfg(0, 0, 0, 0, 2'b00, 2'b00, 0);
        pix(1, 1, 8'h01);
        chk(cap_h == 1, "R5 no mask", cap_h, 1);
        wr_cfg(0, 0, 0, 1, 2'b00, 2'b00, 0);
        pix(1, 1, 8'h02);
        chk(cap_h == 0, "R5 masked", cap_h, 0);
        pix(0, 1, 8'h03);
        chk(cap_h == 1, "R5 mask idle when vsync low", cap_h, 1);
    endtask

    task automatic t_patterns;
        wr_cfg(0, 0, 0, 0, 2'b10, 2'b00, 0);
        frame(2, 0, 2, 22, "R7 R10 R12 hramp");
        wr_cfg(0, 0, 0, 0, 2'b11, 2'b00, 0);
        frame(3, 0, 8, 3, "R8 R12 vramp");
        frame(3, 0, 2, 2, "R10 vramp restart");
        wr_cfg(0, 0, 0, 0, 2'b01, 2'b00, 0);
        frame(1, 0, 1, 18, "R9 bars");
    endtask

    task automatic t_vs_restart;
        wr_cfg(0, 0, 0, 0, 2'b10, 2'b00, 0);
        pix(1, 0, 0); pix(0, 0, 0);
        for (int c = 0; c < 5; c++) pix(0, 1, 8'h00);
        frame(2, 0, 1, 4, "R10 column restart mid line");
    endtask

    task automatic t_fmt_lock;
        wr_cfg(0, 0, 0, 0, 2'b10, 2'b01, 0);
        frame(2, 1, 1, 4, "R11 16-bit");
        wr_cfg(0, 0, 0, 0, 2'b01, 2'b10, 0);
        frame(1, 2, 1, 4, "R11 656");
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_camrst();
        t_passthru();
        t_polarity();
        t_pclk_inv();
        t_mask();
        t_patterns();
        t_vs_restart();
        t_fmt_lock();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule